// File: doc/BRIEF.md
# Driver Enable Sequencer with Bootstrap Refresh

This block decides when a half-bridge gate driver may follow its PWM command. It combines a supply-good status and an active-low disable pin into one of three driver conditions: deep off (supply not good), sleep (supply good but disabled) and enabled. On the way out of either off condition it runs a startup wait, whose length depends on how deep the off condition was, before it lets PWM through. A power-ready output goes high only once that wait is over. The pin it drives is meant to be held strongly low until then, so the pin also serves as a ready flag.

While the driver is enabled, a low bootstrap-capacitor voltage takes priority over the PWM command. The block blocks PWM and sends out short, regularly spaced requests to turn on the low-side switch so that the capacitor recharges. It returns control to PWM only when the upper threshold flag reports a recharged capacitor. Because the entry flag and the exit flag come from different thresholds, the refresh mode has hysteresis. Both thresholds come from analog comparators outside this block. All times are parameters counted in clock cycles.

Top module: `drv_enable_seq`

## Requirements
- R1: During and right after reset, `pwm_en`, `refresh_ls` and `pwr_rdy` are all low.
- R2: One clock edge after `supply_ok` is sampled low, all three outputs are low, whatever `dis_n` is.
- R3: One clock edge after `supply_ok` high and `dis_n` low are sampled, all three outputs are low (sleep).
- R4: Leaving deep off, which means `supply_ok` and `dis_n` both high are first sampled while in deep off, `pwm_en` is low for FULL_DLY edges and rises on edge FULL_DLY+1 counted from that sampling edge.
- R5: Leaving sleep, `pwm_en` rises on edge SLEEP_DLY+1 counted from the edge that first samples `dis_n` high.
- R6: `pwr_rdy` stays low during the startup wait. It is high whenever `pwm_en` is high or refresh is active.
- R7: When `boot_low` is sampled high while `pwm_en` is high, `pwm_en` falls on the next edge and refresh begins with `refresh_ls` high in that same cycle.
- R8: During refresh, `refresh_ls` is high for RF_PW cycles out of every RF_PER cycles. The first pulse starts in the first refresh cycle.
- R9: Refresh ends only on a sampled high `boot_ok`. `pwm_en` returns and `refresh_ls` drops one edge later. `boot_low` falling alone changes nothing.
- R10: Losing `supply_ok` or `dis_n` aborts any startup wait or refresh on the next edge. Leaving the resulting off condition then needs the full wait that belongs to that condition.
- R11: `pwm_en` and `refresh_ls` are never high together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| supply_ok | input | 1 | Supply above its undervoltage threshold |
| dis_n | input | 1 | Disable pin, low puts the driver to sleep |
| boot_low | input | 1 | Bootstrap voltage below the lower refresh threshold |
| boot_ok | input | 1 | Bootstrap voltage above the upper refresh threshold |
| pwm_en | output | 1 | Gates may follow the PWM command |
| refresh_ls | output | 1 | Request to pulse the low-side switch for bootstrap recharge |
| pwr_rdy | output | 1 | Startup complete; the fault pin is released from its strong pull-down |

## Verification
The properties assume that the comparator flags are already synchronous to `clk` and that `boot_low` and `boot_ok` are never high together, since one voltage cannot be below the lower threshold and above the upper one at the same time. The bench changes every input only on the falling edge. It always lowers `boot_ok` before it raises `boot_low`, and lowers `boot_low` before it raises `boot_ok`, so the flags never overlap. The bench shortens all timing parameters so that both startup waits and several refresh periods fit into a short run.

// File: rtl/enseq_pkg.sv
package enseq_pkg;
    typedef enum logic [2:0] {
        ST_OFF     = 3'd0,
        ST_SLEEP   = 3'd1,
        ST_WAKE    = 3'd2,
        ST_RUN     = 3'd3,
        ST_REFRESH = 3'd4
    } seq_state_e;

    function automatic logic state_ready(input seq_state_e s);
        return (s == ST_RUN) || (s == ST_REFRESH);
    endfunction
endpackage

// File: rtl/enseq_delay.sv
module enseq_delay #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         done
);
    typedef struct packed {
        logic [W-1:0] cnt;
    } dly_reg_t;

    dly_reg_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (load) begin
            r_d.cnt = load_val;
        end else if (r_q.cnt != '0) begin
            r_d.cnt = r_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign done = (r_q.cnt == '0);
endmodule

// File: rtl/enseq_refresh_gen.sv
module enseq_refresh_gen #(
    parameter int RF_PW  = 8,
    parameter int RF_PER = 500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic pulse
);
    localparam int CW = $clog2(RF_PER);
    localparam logic [CW-1:0] LAST  = CW'(RF_PER - 1);
    localparam logic [CW-1:0] WIDTH = CW'(RF_PW);

    typedef struct packed {
        logic          active;
        logic [CW-1:0] cnt;
    } rf_reg_t;

    rf_reg_t r_d, r_q;

    always_comb begin
        r_d        = r_q;
        r_d.active = run;
        if (!run || !r_q.active) begin
            r_d.cnt = '0;
        end else if (r_q.cnt == LAST) begin
            r_d.cnt = '0;
        end else begin
            r_d.cnt = r_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign pulse = r_q.active && (r_q.cnt < WIDTH);
endmodule

// File: rtl/drv_enable_seq.sv
module drv_enable_seq
    import enseq_pkg::*;
#(
    parameter int FULL_DLY  = 2000,
    parameter int SLEEP_DLY = 1500,
    parameter int RF_PW     = 8,
    parameter int RF_PER    = 500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic supply_ok,
    input  logic dis_n,
    input  logic boot_low,
    input  logic boot_ok,
    output logic pwm_en,
    output logic refresh_ls,
    output logic pwr_rdy
);
    localparam int DMAX = (FULL_DLY > SLEEP_DLY) ? FULL_DLY : SLEEP_DLY;
    localparam int DW   = $clog2(DMAX);
    localparam logic [DW-1:0] FULL_LOAD  = DW'(FULL_DLY - 1);
    localparam logic [DW-1:0] SLEEP_LOAD = DW'(SLEEP_DLY - 1);

    typedef struct packed {
        seq_state_e st;
    } seq_reg_t;

    seq_reg_t    r_d, r_q;
    logic        dly_load;
    logic [DW-1:0] dly_val;
    logic        dly_done;
    logic        rf_run;
    logic        rf_pulse;

    // Hold the wait counter at the length matching the current off depth
    always_comb begin
        dly_load = (r_q.st == ST_OFF) || (r_q.st == ST_SLEEP);
        dly_val  = (r_q.st == ST_OFF) ? FULL_LOAD : SLEEP_LOAD;
    end

    enseq_delay #(.W(DW)) u_dly (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (dly_load),
        .load_val (dly_val),
        .done     (dly_done)
    );

    always_comb begin
        r_d = r_q;
        if (!supply_ok) begin
            r_d.st = ST_OFF;
        end else if (!dis_n) begin
            r_d.st = ST_SLEEP;
        end else begin
            unique case (r_q.st)
                ST_OFF, ST_SLEEP: r_d.st = ST_WAKE;
                ST_WAKE:          if (dly_done) r_d.st = ST_RUN;
                ST_RUN:           if (boot_low) r_d.st = ST_REFRESH;
                ST_REFRESH:       if (boot_ok)  r_d.st = ST_RUN;
                default:          r_d.st = ST_OFF;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{st: ST_OFF};
        else        r_q <= r_d;
    end

    // Pulse generator phase follows the registered state one-to-one
    assign rf_run = (r_d.st == ST_REFRESH);

    enseq_refresh_gen #(.RF_PW(RF_PW), .RF_PER(RF_PER)) u_rf (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (rf_run),
        .pulse (rf_pulse)
    );

    assign pwm_en     = (r_q.st == ST_RUN);
    assign refresh_ls = rf_pulse && (r_q.st == ST_REFRESH);
    assign pwr_rdy    = state_ready(r_q.st);
endmodule

// File: rtl/enseq_checker.sv
module enseq_checker (
    input logic clk,
    input logic rst_n,
    input logic supply_ok,
    input logic dis_n,
    input logic boot_low,
    input logic boot_ok,
    input logic pwm_en,
    input logic refresh_ls,
    input logic pwr_rdy
);
    a_r2_deep_off: assert property (@(posedge clk) disable iff (!rst_n)
        !supply_ok |=> (!pwm_en && !refresh_ls && !pwr_rdy));

    a_r3_sleep_off: assert property (@(posedge clk) disable iff (!rst_n)
        (supply_ok && !dis_n) |=> (!pwm_en && !refresh_ls && !pwr_rdy));

    a_r11_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(pwm_en && refresh_ls));

    a_r6_ready_cover: assert property (@(posedge clk) disable iff (!rst_n)
        (pwm_en || refresh_ls) |-> pwr_rdy);

    a_r7_refresh_entry: assert property (@(posedge clk) disable iff (!rst_n)
        (pwm_en && boot_low && supply_ok && dis_n) |=> (!pwm_en && pwr_rdy));

    a_r9_refresh_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_rdy && !pwm_en && !boot_ok && supply_ok && dis_n) |=> (!pwm_en && pwr_rdy));

    a_r9_refresh_exit: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_rdy && !pwm_en && boot_ok && !boot_low && supply_ok && dis_n) |=> pwm_en);

    a_r4_enable_source: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pwm_en) |-> ($past(supply_ok) && $past(dis_n)));
endmodule

bind drv_enable_seq enseq_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .supply_ok  (supply_ok),
    .dis_n      (dis_n),
    .boot_low   (boot_low),
    .boot_ok    (boot_ok),
    .pwm_en     (pwm_en),
    .refresh_ls (refresh_ls),
    .pwr_rdy    (pwr_rdy)
);

// File: tb/sim_drv_enable_seq.sv
module sim_drv_enable_seq;
    localparam int FULL  = 40;
    localparam int SLEEP = 30;
    localparam int PW    = 4;
    localparam int PER   = 20;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic supply_ok = 1'b0;
    logic dis_n = 1'b0;
    logic boot_low = 1'b0;
    logic boot_ok = 1'b1;
    logic pwm_en, refresh_ls, pwr_rdy;
    int   n_checks = 0;
    int   n_errors = 0;
    logic finished = 1'b0;

    always #10 clk = ~clk;

    drv_enable_seq #(
        .FULL_DLY(FULL), .SLEEP_DLY(SLEEP), .RF_PW(PW), .RF_PER(PER)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .dis_n(dis_n),
        .boot_low(boot_low), .boot_ok(boot_ok),
        .pwm_en(pwm_en), .refresh_ls(refresh_ls), .pwr_rdy(pwr_rdy)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic int outs();
        return {29'd0, pwm_en, refresh_ls, pwr_rdy};
    endfunction

    task automatic t_reset();
        step(3);
        chk("R1 outputs in reset", outs(), 0);
        rst_n = 1'b1;
        step(2);
        chk("R1 outputs after reset", outs(), 0);
    endtask

    task automatic t_full_startup();
        dis_n = 1'b1;
        step(5);
        chk("R2 deep off with dis_n high", outs(), 0);
        supply_ok = 1'b1;
        step(FULL);
        chk("R4 pwm_en held during full wait", int'(pwm_en), 0);
        chk("R6 pwr_rdy low during full wait", int'(pwr_rdy), 0);
        step(1);
        chk("R4 pwm_en after full wait", int'(pwm_en), 1);
        chk("R6 pwr_rdy after full wait", int'(pwr_rdy), 1);
    endtask

    task automatic t_sleep_startup();
        dis_n = 1'b0;
        step(1);
        chk("R3 sleep outputs", outs(), 0);
        step(5);
        dis_n = 1'b1;
        step(SLEEP);
        chk("R5 pwm_en held during sleep wait", int'(pwm_en), 0);
        step(1);
        chk("R5 pwm_en after sleep wait", int'(pwm_en), 1);
    endtask

    task automatic t_refresh();
        int bad = 0;
        boot_ok  = 1'b0;
        boot_low = 1'b1;
        step(1);
        chk("R7 pwm_en drops on boot_low", int'(pwm_en), 0);
        chk("R7 first refresh pulse", int'(refresh_ls), 1);
        for (int i = 0; i < 2 * PER; i++) begin
            if (int'(refresh_ls) != (((i % PER) < PW) ? 1 : 0)) bad++;
            if (!pwr_rdy || pwm_en) bad++;
            step(1);
        end
        chk("R8 pulse pattern mismatches", bad, 0);
        chk("R11 pwm_en low during refresh", int'(pwm_en), 0);
    endtask

    task automatic t_hysteresis();
        int seen = 0;
        boot_low = 1'b0;
        for (int i = 0; i < PER; i++) begin
            step(1);
            if (pwm_en) seen += 100;
            if (refresh_ls) seen++;
        end
        chk("R9 refresh persists between thresholds", seen, PW);
        boot_ok = 1'b1;
        step(1);
        chk("R9 pwm_en back on boot_ok", int'(pwm_en), 1);
        chk("R9 refresh_ls off on boot_ok", int'(refresh_ls), 0);
    endtask

    task automatic t_abort();
        boot_ok  = 1'b0;
        boot_low = 1'b1;
        step(1);
        chk("R7 refresh pulse before abort", int'(refresh_ls), 1);
        supply_ok = 1'b0;
        step(1);
        chk("R10 supply loss aborts refresh", outs(), 0);
        boot_low = 1'b0;
        step(1);
        boot_ok   = 1'b1;
        step(1);
        supply_ok = 1'b1;
        step(FULL);
        chk("R10 full wait after supply loss", int'(pwm_en), 0);
        step(1);
        chk("R10 enabled after full wait", int'(pwm_en), 1);
        supply_ok = 1'b0;
        step(2);
        supply_ok = 1'b1;
        step(10);
        dis_n = 1'b0;
        step(1);
        chk("R10 disable aborts startup", outs(), 0);
        dis_n = 1'b1;
        step(SLEEP);
        chk("R10 sleep wait restarts", int'(pwm_en), 0);
        step(1);
        chk("R10 enabled after restarted wait", int'(pwm_en), 1);
    endtask

    initial begin
        t_reset();
        t_full_startup();
        t_sleep_startup();
        t_refresh();
        t_hysteresis();
        t_abort();
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end
endmodule